// File: doc/BRIEF.md
# Compute-Transfer Phase Sequencer

This block schedules a chain of processing blocks that act as consecutive pipeline layers. The blocks never compute and exchange data at the same time. Each round has three steps. In the first step, every block computes in parallel and every inter-block link is open. In the second and third steps, the links between neighbours close in two groups, chosen by whether the sending block has an odd or an even index. Because of this split, every link is used once per round, and no block is a sender and a receiver in the same step.

Link `k` joins block `k` (the sender) to block `k+1` (the receiver). The sequencer drives one compute enable per block and one switch enable per link, and it reports its current step. A stall request pauses the schedule, but only between rounds, so a round that has started always completes. A fill counter counts completed rounds. It marks the end of each round as carrying a valid result from the last block once the first input value has had time to cross the whole chain. A stall does not clear this count.

Top module: `cts_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, `phase_o` is 0 (hold), and all compute enables, link enables and `out_valid_o` are 0.
- R2: When `phase_o` is 1 (compute), every bit of `comp_en_o` is 1 and every bit of `link_en_o` is 0.
- R3: A round runs compute (1), then odd-sender transfer (2), then even-sender transfer (3), one clock cycle each, with no gap between the steps.
- R4: When `phase_o` is 2, `link_en_o[k]` is 1 exactly for the odd values of `k`, and `comp_en_o` is all 0.
- R5: When `phase_o` is 3, `link_en_o[k]` is 1 exactly for the even values of `k`, and `comp_en_o` is all 0.
- R6: No compute enable is high in a cycle in which any link enable is high. In hold (0), every enable is low.
- R7: `stall_i` takes effect only at a round boundary. If it is high in a step-3 cycle or in a hold cycle, the next cycle is hold. If it is high during step 1 or step 2, it has no effect on the schedule.
- R8: In a hold cycle with `stall_i` low, the next cycle is compute (1).
- R9: `out_valid_o` is high only in step-3 cycles, and only from the round with index N_BLK-1 onwards. Rounds are counted from 0 after reset.
- R10: Hold periods do not reset the fill count. Once the chain has filled, `out_valid_o` returns in the first round after a stall ends.
- R11: Consider a chain model in which each block adds one during compute and each closed link copies the sender's result into the receiver's input. Under the enables this block drives, the last block's result in round `r` (for `r` >= N_BLK-1) equals `r+1`, given that block 0 is fed the round index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Request to pause at the next round boundary |
| phase_o | output | 2 | Current step: 0 hold, 1 compute, 2 odd-sender transfer, 3 even-sender transfer |
| comp_en_o | output | N_BLK | Per-block compute enable |
| link_en_o | output | N_BLK-1 | Per-link switch enable; bit k joins block k to block k+1 |
| out_valid_o | output | 1 | The last block's result is valid in this cycle |

## Verification
The stall request and the result-valid flag can both fall on the last transfer step of a round. That step is also where the fill counter advances, and where the next round would begin. The bench raises `stall_i` in exactly such a flagged step, after the chain has filled. It then expects the flag to remain high in that cycle, the next cycle to be hold, and the flag to reappear without a refill in the first round after the stall is released. A block model in the bench runs under the driven enables, so a flag that is present but wrong is caught by comparing the value that leaves the last block.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_COMP  = 2'd1,
    PH_XODD  = 2'd2,
    PH_XEVEN = 2'd3
  } phase_t;

  // Step that follows cur; stall only matters at a round boundary.
  function automatic phase_t next_phase(phase_t cur, logic stall);
    phase_t nxt;
    case (cur)
      PH_HOLD:  nxt = stall ? PH_HOLD : PH_COMP;
      PH_COMP:  nxt = PH_XODD;
      PH_XODD:  nxt = PH_XEVEN;
      default:  nxt = stall ? PH_HOLD : PH_COMP;
    endcase
    return nxt;
  endfunction

  // A link is closed when its sender's index parity matches the step.
  function automatic logic link_closed(phase_t ph, int unsigned sender);
    logic odd_sender;
    odd_sender = (sender % 2) == 1;
    return ((ph == PH_XODD) && odd_sender) || ((ph == PH_XEVEN) && !odd_sender);
  endfunction

  function automatic logic is_round_end(phase_t ph);
    return ph == PH_XEVEN;
  endfunction

endpackage

// File: rtl/cts_phase_fsm.sv
module cts_phase_fsm
  import cts_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall_i,
  output phase_t phase_o,
  output logic   round_end_o
);

  phase_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_HOLD;
    else        state_q <= next_phase(state_q, stall_i);
  end

  assign phase_o     = state_q;
  assign round_end_o = is_round_end(state_q);

endmodule

// File: rtl/cts_link_ctrl.sv
module cts_link_ctrl
  import cts_pkg::*;
#(
  parameter int N_LINK = 5
) (
  input  phase_t            phase_i,
  output logic [N_LINK-1:0] link_en_o
);

  for (genvar g = 0; g < N_LINK; g++) begin : g_link
    assign link_en_o[g] = link_closed(phase_i, g);
  end

endmodule

// File: rtl/cts_fill_track.sv
module cts_fill_track #(
  parameter int N_BLK = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic round_end_i,
  output logic filled_o,
  output logic out_valid_o
);

  localparam int CW = (N_BLK > 2) ? $clog2(N_BLK) : 1;
  localparam logic [CW-1:0] FULL = CW'(N_BLK - 1);

  logic [CW-1:0] done_q;

  // Completed rounds, saturating once the chain is full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            done_q <= '0;
    else if (round_end_i && done_q != FULL) done_q <= done_q + 1'b1;
  end

  assign filled_o    = (done_q == FULL);
  assign out_valid_o = round_end_i && filled_o;

endmodule

// File: rtl/cts_sequencer.sv
module cts_sequencer
  import cts_pkg::*;
#(
  parameter int N_BLK = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  output logic [1:0]       phase_o,
  output logic [N_BLK-1:0] comp_en_o,
  output logic [N_BLK-2:0] link_en_o,
  output logic             out_valid_o
);

  localparam int N_LINK = N_BLK - 1;

  phase_t phase;
  logic   round_end;
  logic   filled;
  logic   compute_step;

  cts_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .phase_o     (phase),
    .round_end_o (round_end)
  );

  cts_link_ctrl #(.N_LINK(N_LINK)) u_links (
    .phase_i   (phase),
    .link_en_o (link_en_o)
  );

  cts_fill_track #(.N_BLK(N_BLK)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .round_end_i (round_end),
    .filled_o    (filled),
    .out_valid_o (out_valid_o)
  );

  assign compute_step = (phase == PH_COMP);

  for (genvar b = 0; b < N_BLK; b++) begin : g_comp
    assign comp_en_o[b] = compute_step;
  end

  assign phase_o = phase;

endmodule

// File: rtl/cts_sequencer_chk.sv
module cts_sequencer_chk #(
  parameter int N_BLK = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic [1:0]       phase,
  input logic [N_BLK-1:0] comp_en,
  input logic [N_BLK-2:0] link_en,
  input logic             out_valid,
  input logic             filled
);

  localparam int NL = N_BLK - 1;

  logic [NL-1:0] odd_mask;
  for (genvar g = 0; g < NL; g++) begin : g_mask
    assign odd_mask[g] = (g % 2) == 1;
  end

  AST_COMPUTE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> (&comp_en && link_en == '0)); // R2
  AST_ORDER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |=> (phase == 2'd2)); // R3
  AST_ORDER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> (phase == 2'd3)); // R3
  AST_ODD_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |-> (link_en == odd_mask && comp_en == '0)); // R4
  AST_EVEN_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |-> (link_en == ~odd_mask && comp_en == '0)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|link_en) |-> (comp_en == '0)); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (comp_en == '0 && link_en == '0)); // R6
  AST_STALL_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 2'd3 || phase == 2'd0) && stall) |=> (phase == 2'd0)); // R7
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !stall) |=> (phase == 2'd1)); // R8
  AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase == 2'd3 && filled)); // R9
  AST_FILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled); // R10

endmodule

bind cts_sequencer cts_sequencer_chk #(.N_BLK(N_BLK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall_i),
  .phase     (phase_o),
  .comp_en   (comp_en_o),
  .link_en   (link_en_o),
  .out_valid (out_valid_o),
  .filled    (filled)
);

// File: tb/sim_cts_sequencer.sv
`timescale 1ns/1ps
module sim_cts_sequencer;

  localparam int N  = 6;
  localparam int NL = N - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b1;
  logic [1:0]    phase;
  logic [N-1:0]  comp_en;
  logic [NL-1:0] link_en;
  logic          out_valid;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cts_sequencer #(.N_BLK(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall),
    .phase_o(phase), .comp_en_o(comp_en), .link_en_o(link_en),
    .out_valid_o(out_valid)
  );

  // Chain model: each block adds one on compute, links copy forward.
  logic [15:0] bin  [N];
  logic [15:0] bout [N];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin bin[i] <= '0; bout[i] <= '0; end
    end else begin
      for (int i = 0; i < N; i++) if (comp_en[i]) bout[i] <= bin[i] + 16'd1;
      for (int i = 0; i < NL; i++) if (link_en[i]) bin[i+1] <= bout[i];
      if (phase == 2'd3) bin[0] <= bin[0] + 16'd1;
    end
  end

  typedef struct {
    int    ph;
    bit    vld;
    int    rnd;
    string tag;
  } item_t;

  item_t q[$];
  int    mph   = 0;
  int    mdone = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_links(int ph);
    logic [NL-1:0] e;
    for (int i = 0; i < NL; i++)
      e[i] = (ph == 2 && (i % 2) == 1) || (ph == 3 && (i % 2) == 0);
    return e;
  endfunction

  // Driver: applies stall and queues what the next cycle must show.
  task automatic cyc(bit s, string tag);
    item_t it;
    int    nx;
    @(negedge clk);
    stall = s;
    case (mph)
      0:       nx = s ? 0 : 1;
      1:       nx = 2;
      2:       nx = 3;
      default: nx = s ? 0 : 1;
    endcase
    if (mph == 3) mdone++;
    mph    = nx;
    it.ph  = nx;
    it.rnd = mdone;
    it.vld = (nx == 3) && (mdone >= N - 1);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: pops expectations and compares away from the edge.
  always begin
    item_t it;
    logic [N-1:0]  ec;
    logic [NL-1:0] el;
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      ec = (it.ph == 1) ? '1 : '0;
      el = exp_links(it.ph);
      chk(phase == 2'(it.ph), it.tag, "phase", int'(phase), it.ph);
      chk(comp_en == ec, (it.ph == 1) ? "R2" : "R6", "comp_en", int'(comp_en), int'(ec));
      chk(link_en == el, (it.ph == 2) ? "R4" : ((it.ph == 3) ? "R5" : "R6"),
          "link_en", int'(link_en), int'(el));
      chk(out_valid == it.vld, (it.tag == "R10") ? "R10" : "R9", "out_valid",
          int'(out_valid), int'(it.vld));
      if (it.vld)
        chk(bout[N-1] == 16'(it.rnd + 1), "R11", "last block result",
            int'(bout[N-1]), it.rnd + 1);
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && comp_en == '0 && link_en == '0 && !out_valid,
        "R1", "outputs in reset", int'(phase), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(phase == 2'd0 && comp_en == '0 && link_en == '0 && !out_valid,
        "R1", "outputs after release", int'(phase), 0);

    // Held in hold, then released.
    cyc(1, "R8"); cyc(1, "R8"); cyc(0, "R8");
    // Stall raised mid-round is ignored until the boundary.
    cyc(1, "R7"); cyc(1, "R7"); cyc(1, "R7"); cyc(1, "R7");
    cyc(0, "R8");
    // Free run until the chain fills.
    repeat (3 * N + 3) cyc(0, "R3");
    while (mph != 3) cyc(0, "R3");
    // Stall lands on a flagged round end; fill must survive.
    cyc(1, "R10");
    repeat (3) cyc(1, "R10");
    repeat (10) cyc(0, "R10");
    // Single-cycle stall pulse on a compute step.
    while (mph != 1) cyc(0, "R3");
    cyc(1, "R7");
    repeat (6) cyc(0, "R3");

    @(posedge clk); #3;
    @(posedge clk); #3;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule